// File: doc/BRIEF.md
# Cell Receive Master with Odd Parity

This block is the receive side of the master in a link where cells move under cell-level handshaking. An external poller selects the device and pulses a start request. If the selected device also reports that a complete cell is ready, the block drives its receive enable for exactly one cell's worth of transfers. The device answers each enabled cycle by presenting one word in the following cycle. The block samples the data bus, the start-of-cell flag and the parity bit on rising clock edges. It reassembles the words into an output stream that carries a valid, a first-of-cell marker and a last-of-cell marker.

Every sampled word is checked against odd parity. In the 8-bit mode only the low byte counts. In the 16-bit mode the whole bus counts. When checking is enabled and any word of a cell fails, the cell ends without a last marker and a one-cycle drop pulse is raised instead. The downstream buffer discards what it has collected. A start-of-cell that arrives before the running cell is complete also raises the drop pulse and begins a fresh cell. In the 8-bit mode a cell is 53 transfers. In the 16-bit mode it is 27 transfers, where the spare byte is a pad.

Two state machines do the work. The enable sequencer has states EN_IDLE and EN_RUN. Transition GRANT goes from EN_IDLE to EN_RUN when the start request and cell-available are both high. Transition DONE goes back to EN_IDLE after the last enabled cycle. The assembler has states CAP_IDLE and CAP_CELL. Transition START goes from CAP_IDLE to CAP_CELL on a sampled start-of-cell. RESTART stays in CAP_CELL on a premature start-of-cell. COMPLETE goes from CAP_CELL to CAP_IDLE on the final word of the cell.

Top module: `cellrx_master`

## Requirements
- R1: While reset (rst_n low) is applied, rx_enb, cell_valid, cell_first, cell_last and cell_drop are all 0.
- R2: rx_enb rises only in the cycle after one where poll_go and rx_clav were both sampled high. Once it rises, it stays high for exactly L consecutive cycles, where L is 53 when wide_mode=0 and 27 when wide_mode=1.
- R3: A word is sampled only at the clock edge that ends the cycle following a cycle with rx_enb high. It appears on cell_valid/cell_data one cycle after that edge. So the first cell_valid comes three cycles after poll_go is accepted, and words presented while rx_enb was low in the previous cycle produce no output.
- R4: A sampled word with rx_soc=1 is output with cell_first=1, and the word count of the cell restarts at 1.
- R5: Parity is odd. A word passes when the XOR of rx_par and the data bits in use is 1. Bits [7:0] are in use when wide_mode=0 and bits [15:0] when wide_mode=1.
- R6: The L-th word after start-of-cell is output with cell_last=1 and cell_drop=0 when no word of that cell failed parity, or when checking is off.
- R7: With par_check_en=1, a parity failure on any word of the cell, including the first or the last, makes the L-th word carry cell_last=0 and cell_drop=1 for one cycle.
- R8: With par_check_en=0, parity failures have no effect, and the cell ends with cell_last=1.
- R9: A start-of-cell sampled before the running cell has reached L words pulses cell_drop together with the new first word. The new cell completes only after L further words.
- R10: Sampled words without start-of-cell outside a cell produce no cell_valid.
- R11: cell_data equals the sampled rx_data when wide_mode=1. When wide_mode=0, it equals rx_data[7:0] with bits [15:8] forced to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_mode | input | 1 | 1 selects 16-bit transfers, 0 selects 8-bit |
| par_check_en | input | 1 | 1 enables dropping of cells with parity errors |
| poll_go | input | 1 | Start request from the external poller for the selected device |
| rx_clav | input | 1 | Cell-available from the selected device |
| rx_data | input | 16 | Receive data bus, bit 15 most significant |
| rx_soc | input | 1 | Start-of-cell flag with the first word |
| rx_par | input | 1 | Odd parity bit over the data in use |
| rx_enb | output | 1 | Receive enable to the device |
| cell_valid | output | 1 | Output word valid |
| cell_data | output | 16 | Output word |
| cell_first | output | 1 | Output word is the first of a cell |
| cell_last | output | 1 | Output word ends a good cell |
| cell_drop | output | 1 | One-cycle pulse: current cell is discarded |

## Verification
The bench targets parity errors on the first and the final word of a cell. A design that latches the error one word late would still mark the first case good, or would miss the last. It drives 8-bit cells whose upper data bits are busy, which exposes a parity tree or an output path that reads unused bits. It sends a premature start-of-cell, including one on the final word, so that a design which completes instead of restarting is caught. It also measures the one-cycle lag between enable and capture, and presents start-of-cell outside an enable window, where a design that samples on the enable itself would emit words.

// File: rtl/cellrx_pkg.sv
package cellrx_pkg;

    typedef enum logic [0:0] {
        EN_IDLE = 1'b0,
        EN_RUN  = 1'b1
    } en_state_t;

    typedef enum logic [0:0] {
        CAP_IDLE = 1'b0,
        CAP_CELL = 1'b1
    } cap_state_t;

    // Odd parity: XOR of all bits in use plus the parity bit must be 1
    function automatic logic odd_ok(input logic [15:0] d, input logic wide, input logic p);
        logic acc;
        acc = wide ? ^d : ^d[7:0];
        return acc ^ p;
    endfunction

endpackage

// File: rtl/cellrx_enable_fsm.sv
module cellrx_enable_fsm
    import cellrx_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             poll_go,
    input  logic             rx_clav,
    input  logic [CNT_W-1:0] len,
    output logic             rx_enb
);

    en_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= EN_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state: GRANT and DONE transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            EN_IDLE: begin
                cnt_d = '0;
                if (poll_go && rx_clav) begin
                    state_d = EN_RUN;
                end
            end
            EN_RUN: begin
                if (cnt_q == len - CNT_W'(1)) begin
                    state_d = EN_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            default: state_d = EN_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rx_enb = (state_q == EN_RUN);
    end

endmodule

// File: rtl/cellrx_capture.sv
module cellrx_capture
    import cellrx_pkg::*;
#(
    parameter int BUS_W = 16,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             wide_mode,
    input  logic             par_check_en,
    input  logic [CNT_W-1:0] len,
    input  logic [BUS_W-1:0] rx_data,
    input  logic             rx_soc,
    input  logic             rx_par,
    output logic             cell_valid,
    output logic [BUS_W-1:0] cell_data,
    output logic             cell_first,
    output logic             cell_last,
    output logic             cell_drop
);

    localparam int HALF_W = BUS_W / 2;

    cap_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             err_q, err_d;
    logic             bad;
    logic [BUS_W-1:0] word_in;
    logic             valid_d, first_d, last_d, drop_d;

    // lane masking for the narrow mode
    for (genvar b = 0; b < BUS_W; b++) begin : g_lane
        if (b < HALF_W) begin : g_low
            assign word_in[b] = rx_data[b];
        end else begin : g_high
            assign word_in[b] = wide_mode & rx_data[b];
        end
    end

    assign bad = par_check_en && !odd_ok(rx_data, wide_mode, rx_par);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CAP_IDLE;
            cnt_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            err_q   <= err_d;
        end
    end

    // next state: START, RESTART, COMPLETE
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        err_d   = err_q;
        valid_d = 1'b0;
        first_d = 1'b0;
        last_d  = 1'b0;
        drop_d  = 1'b0;
        unique case (state_q)
            CAP_IDLE: begin
                if (take && rx_soc) begin
                    state_d = CAP_CELL;
                    cnt_d   = CNT_W'(1);
                    err_d   = bad;
                    valid_d = 1'b1;
                    first_d = 1'b1;
                end
            end
            CAP_CELL: begin
                if (take && rx_soc) begin
                    cnt_d   = CNT_W'(1);
                    err_d   = bad;
                    valid_d = 1'b1;
                    first_d = 1'b1;
                    drop_d  = 1'b1;
                end else if (take) begin
                    valid_d = 1'b1;
                    if (cnt_q == len - CNT_W'(1)) begin
                        state_d = CAP_IDLE;
                        cnt_d   = '0;
                        err_d   = 1'b0;
                        last_d  = !(err_q || bad);
                        drop_d  = err_q || bad;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                        err_d = err_q || bad;
                    end
                end
            end
            default: state_d = CAP_IDLE;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cell_valid <= 1'b0;
            cell_data  <= '0;
            cell_first <= 1'b0;
            cell_last  <= 1'b0;
            cell_drop  <= 1'b0;
        end else begin
            cell_valid <= valid_d;
            cell_first <= first_d;
            cell_last  <= last_d;
            cell_drop  <= drop_d;
            if (valid_d) begin
                cell_data <= word_in;
            end
        end
    end

endmodule

// File: rtl/cellrx_master.sv
module cellrx_master
    import cellrx_pkg::*;
#(
    parameter int CELL_OCTETS = 53,
    parameter int BUS_W       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wide_mode,
    input  logic             par_check_en,
    input  logic             poll_go,
    input  logic             rx_clav,
    input  logic [BUS_W-1:0] rx_data,
    input  logic             rx_soc,
    input  logic             rx_par,
    output logic             rx_enb,
    output logic             cell_valid,
    output logic [BUS_W-1:0] cell_data,
    output logic             cell_first,
    output logic             cell_last,
    output logic             cell_drop
);

    localparam int LEN_NARROW = CELL_OCTETS;
    localparam int LEN_WIDE   = (CELL_OCTETS + 1) / 2;
    localparam int CNT_W      = $clog2(CELL_OCTETS + 1);

    logic [CNT_W-1:0] len;
    logic             enb_q;

    assign len = wide_mode ? CNT_W'(LEN_WIDE) : CNT_W'(LEN_NARROW);

    // capture lags the enable by one cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enb_q <= 1'b0;
        end else begin
            enb_q <= rx_enb;
        end
    end

    cellrx_enable_fsm #(.CNT_W(CNT_W)) u_enable (
        .clk     (clk),
        .rst_n   (rst_n),
        .poll_go (poll_go),
        .rx_clav (rx_clav),
        .len     (len),
        .rx_enb  (rx_enb)
    );

    cellrx_capture #(.BUS_W(BUS_W), .CNT_W(CNT_W)) u_capture (
        .clk          (clk),
        .rst_n        (rst_n),
        .take         (enb_q),
        .wide_mode    (wide_mode),
        .par_check_en (par_check_en),
        .len          (len),
        .rx_data      (rx_data),
        .rx_soc       (rx_soc),
        .rx_par       (rx_par),
        .cell_valid   (cell_valid),
        .cell_data    (cell_data),
        .cell_first   (cell_first),
        .cell_last    (cell_last),
        .cell_drop    (cell_drop)
    );

endmodule

// File: rtl/cellrx_master_chk.sv
module cellrx_master_chk (
    input logic clk,
    input logic rst_n,
    input logic poll_go,
    input logic rx_clav,
    input logic rx_enb,
    input logic cell_valid,
    input logic cell_first,
    input logic cell_last,
    input logic cell_drop
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> !rx_enb && !cell_valid && !cell_first && !cell_last && !cell_drop); // R1

    AST_ENB_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_enb) |-> $past(poll_go && rx_clav)); // R2

    AST_CAPTURE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        cell_valid |-> $past(rx_enb, 2)); // R3

    AST_FIRST_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        cell_first |-> cell_valid); // R4

    AST_LAST_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        cell_last |-> cell_valid && !cell_first); // R6

    AST_LAST_OR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !(cell_last && cell_drop)); // R7

endmodule

bind cellrx_master cellrx_master_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .poll_go    (poll_go),
    .rx_clav    (rx_clav),
    .rx_enb     (rx_enb),
    .cell_valid (cell_valid),
    .cell_first (cell_first),
    .cell_last  (cell_last),
    .cell_drop  (cell_drop)
);

// File: tb/cellrx_master_bench.sv
module cellrx_master_bench;

    typedef struct packed {
        logic       wide;
        logic       chk;
        logic [7:0] errpos;  // 1-based word with bad parity, 0 none
        logic [7:0] sft;     // 1 normal, 0 no start-of-cell, >1 extra start at that word
        logic [2:0] nfirst;
        logic       nlast;
        logic [2:0] ndrop;
        logic [6:0] nvalid;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 8'd0,  8'd1,  3'd1, 1'b1, 3'd0, 7'd53},
        '{1'b1, 1'b1, 8'd0,  8'd1,  3'd1, 1'b1, 3'd0, 7'd27},
        '{1'b0, 1'b1, 8'd10, 8'd1,  3'd1, 1'b0, 3'd1, 7'd53},
        '{1'b1, 1'b1, 8'd27, 8'd1,  3'd1, 1'b0, 3'd1, 7'd27},
        '{1'b0, 1'b0, 8'd5,  8'd1,  3'd1, 1'b1, 3'd0, 7'd53},
        '{1'b1, 1'b0, 8'd1,  8'd1,  3'd1, 1'b1, 3'd0, 7'd27},
        '{1'b0, 1'b1, 8'd0,  8'd20, 3'd2, 1'b0, 3'd1, 7'd53},
        '{1'b1, 1'b1, 8'd1,  8'd1,  3'd1, 1'b0, 3'd1, 7'd27},
        '{1'b1, 1'b1, 8'd0,  8'd0,  3'd0, 1'b0, 3'd0, 7'd0},
        '{1'b1, 1'b1, 8'd0,  8'd27, 3'd2, 1'b0, 3'd1, 7'd27}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wide_mode = 1'b0;
    logic        par_check_en = 1'b0;
    logic        poll_go = 1'b0;
    logic        rx_clav = 1'b0;
    logic [15:0] rx_data = '0;
    logic        rx_soc = 1'b0;
    logic        rx_par = 1'b0;
    logic        rx_enb;
    logic        cell_valid;
    logic [15:0] cell_data;
    logic        cell_first;
    logic        cell_last;
    logic        cell_drop;

    int checks = 0;
    int errors = 0;

    // device and monitor state
    int   cur_row = 0;
    int   word_no = 0;
    logic enb_seen = 1'b0;
    logic stray = 1'b0;
    int   n_valid, n_first, n_last, n_drop, data_bad, run, max_run;

    always #4 clk = ~clk;

    cellrx_master u_cellrx_master (
        .clk          (clk),
        .rst_n        (rst_n),
        .wide_mode    (wide_mode),
        .par_check_en (par_check_en),
        .poll_go      (poll_go),
        .rx_clav      (rx_clav),
        .rx_data      (rx_data),
        .rx_soc       (rx_soc),
        .rx_par       (rx_par),
        .rx_enb       (rx_enb),
        .cell_valid   (cell_valid),
        .cell_data    (cell_data),
        .cell_first   (cell_first),
        .cell_last    (cell_last),
        .cell_drop    (cell_drop)
    );

    function automatic logic [15:0] word_of(input int w, input int row);
        return 16'(w * 291 + row * 3855 + 23040);
    endfunction

    function automatic logic [15:0] expect_of(input int w, input int row, input logic wide);
        logic [15:0] v;
        v = word_of(w, row);
        return wide ? v : {8'h00, v[7:0]};
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_counts();
        n_valid = 0; n_first = 0; n_last = 0; n_drop = 0;
        data_bad = 0; run = 0; max_run = 0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        poll_go = 1'b0;
        rx_clav = 1'b0;
        stray = 1'b0;
        repeat (3) @(negedge clk);
        word_no = 0;
        clear_counts();
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // device model and output monitor, both on the falling edge
    initial begin
        clear_counts();
        forever begin
            @(negedge clk);
            if (cell_valid) begin
                n_valid++;
                if (cell_data != expect_of(n_valid, cur_row, wide_mode)) data_bad++;
            end
            if (cell_first) n_first++;
            if (cell_last)  n_last++;
            if (cell_drop)  n_drop++;
            if (rx_enb) begin
                run++;
                if (run > max_run) max_run = run;
            end else begin
                run = 0;
            end
            if (enb_seen) begin
                logic [15:0] v;
                logic        acc;
                word_no++;
                v = word_of(word_no, cur_row);
                acc = wide_mode ? ^v : ^v[7:0];
                rx_data = v;
                rx_soc = (VECS[cur_row].sft != 0 && word_no == 1) ||
                         (VECS[cur_row].sft > 1 && word_no == int'(VECS[cur_row].sft));
                rx_par = (word_no == int'(VECS[cur_row].errpos)) ? acc : ~acc;
            end else begin
                rx_data = 16'h1234;
                rx_soc = stray;
                rx_par = ~^rx_data[7:0];
            end
            enb_seen = rx_enb;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: outputs quiet during reset
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1", "rx_enb in reset", int'(rx_enb), 0);
        check("R1", "cell_valid in reset", int'(cell_valid), 0);
        check("R1", "cell_drop in reset", int'(cell_drop), 0);

        // table of cells
        for (int r = 0; r < NV; r++) begin
            int len;
            cur_row = r;
            wide_mode = VECS[r].wide;
            par_check_en = VECS[r].chk;
            len = VECS[r].wide ? 27 : 53;
            do_reset();
            rx_clav = 1'b1;
            poll_go = 1'b1;
            @(negedge clk);
            poll_go = 1'b0;
            check("R2", "enable after grant", int'(rx_enb), 1);
            @(negedge clk);
            check("R3", "no output before lag", int'(cell_valid), 0);
            @(negedge clk);
            check("R3", "first output three cycles after grant", int'(cell_valid),
                  int'(VECS[r].nvalid != 0));
            repeat (len + 4) @(negedge clk);
            check("R2", "enable run length", max_run, len);
            check("R3/R10", "valid count", n_valid, int'(VECS[r].nvalid));
            check("R4/R9", "first count", n_first, int'(VECS[r].nfirst));
            check("R6/R8", "last count", n_last, int'(VECS[r].nlast));
            check("R7/R9", "drop count", n_drop, int'(VECS[r].ndrop));
            check("R5/R11", "data mismatches", data_bad, 0);
        end

        // R2: no enable without cell-available
        cur_row = 0;
        wide_mode = 1'b0;
        do_reset();
        rx_clav = 1'b0;
        poll_go = 1'b1;
        repeat (6) @(negedge clk);
        poll_go = 1'b0;
        check("R2", "no enable without clav", max_run, 0);

        // R3: start-of-cell while enable idle is not sampled
        stray = 1'b1;
        repeat (6) @(negedge clk);
        stray = 1'b0;
        repeat (2) @(negedge clk);
        check("R3", "stray words produce no output", n_valid, 0);
        check("R1", "no drop from stray words", n_drop, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule